// File: doc/BRIEF.md
# Dual-Section Decade Divider Counter

This block is a four-bit counter made of two separately driven parts: a toggle stage that supplies output bit 0 and a modulo-5 stage that supplies output bits 3..1. Each part has its own count input. A link-select input chooses how the two parts are joined. They can run as two unrelated dividers. They can be chained toggle-first, which gives an 8-4-2-1 decimal count. They can be chained modulo-5-first, which gives a square wave at one tenth of the input rate on bit 0.

The block is fully synchronous to one system clock. Each count input passes through a synchronizer chain, and a high-to-low transition seen at the end of that chain becomes a one-cycle advance. In the chained modes the carry from the first part advances the second part in the same clock cycle as the first part's wrap. An active-high master clear empties all state asynchronously and holds it empty while it stays high. A count input may change at most once every two system clocks.

Top module: `dd_decade_counter`

## Requirements
- R1: While `mr` is high, `q` reads 4'b0000 and no count edge changes it. The clear overrides an advance detected in the same cycle, and counting resumes from zero after release.
- R2: Only a high-to-low transition of a count input advances the counter, and a rising transition has no effect. With SYNC_STAGES=2, `q` still shows the old value two clocks after the falling input change and shows the new value after the third clock.
- R3: Each counted falling edge that reaches the toggle stage inverts `q[0]`.
- R4: The modulo-5 stage steps `q[3:1]` through 0,1,2,3,4 and then back to 0. `q[3]` is high only at count 4.
- R5: With `link`=2'b00, falls on `cp0` advance only the toggle stage and falls on `cp1` advance only the modulo-5 stage.
- R6: With `link`=2'b01, falls on `cp0` drive the toggle stage, and each 1-to-0 step of `q[0]` advances the modulo-5 stage. `q` counts 0 to 9 in decimal and wraps to 0. `cp1` is ignored.
- R7: With `link`=2'b10, falls on `cp1` drive the modulo-5 stage, and each 4-to-0 wrap of that stage inverts `q[0]`. `q[0]` is low for five counts and high for five counts. `cp0` is ignored.
- R8: With `link`=2'b11, the block behaves exactly as with `link`=2'b00.
- R9: A chained carry lands in the same cycle as the wrap. In decimal mode `q` goes straight from 9 to 0 with no intermediate value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| mr | input | 1 | Master clear, active high, asynchronous |
| cp0 | input | 1 | Count input of the toggle stage (falling edge counts) |
| cp1 | input | 1 | Count input of the modulo-5 stage (falling edge counts) |
| link | input | 2 | 00 split, 01 decimal, 10 square-wave, 11 treated as split |
| q | output | 4 | Counter state: q[3:1] modulo-5 stage, q[0] toggle stage |

## Verification
The bench targets the two carries. A decimal chain that took its carry from the wrong edge of bit 0 would count in the wrong order, and a design that carried a cycle late would show a stray value between 9 and 0. In square-wave mode the bench counts high samples of bit 0 over thirty inputs. A design that toggled on the wrong modulo-5 state would break the five-low/five-high split. The bench also holds a count input high to prove that a rising edge counts nothing. It places the master clear on top of a pending edge, where a design giving the edge priority would leave a non-zero value. Finally it checks that the stage not selected by the mode ignores its input.

// File: rtl/dd_pkg.sv
package dd_pkg;
   typedef enum logic [1:0] {
      LINK_SPLIT = 2'b00,
      LINK_BCD   = 2'b01,
      LINK_BIQ   = 2'b10,
      LINK_RSVD  = 2'b11
   } link_e;

   localparam int unsigned QUINT_MOD = 5;
   localparam int unsigned QUINT_W   = $clog2(QUINT_MOD);
   localparam int unsigned OUT_W     = QUINT_W + 1;
endpackage

// File: rtl/dd_fall_detect.sv
module dd_fall_detect #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic mr,
   input  logic din,
   output logic fall
);
   localparam int unsigned TOP = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dd_fall_detect: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              last;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_chain
         if (i == 0) begin : g_first
            always_ff @(posedge clk or posedge mr) begin
               if (mr) chain[i] <= 1'b0;
               else    chain[i] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or posedge mr) begin
               if (mr) chain[i] <= 1'b0;
               else    chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or posedge mr) begin
      if (mr) last <= 1'b0;
      else    last <= chain[TOP];
   end

   assign fall = last & ~chain[TOP];

   AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (mr)
      fall |=> !fall) else $error("fall pulse longer than one cycle"); // R2
endmodule

// File: rtl/dd_toggle_stage.sv
module dd_toggle_stage (
   input  logic clk,
   input  logic mr,
   input  logic adv,
   output logic q
);
   always_ff @(posedge clk or posedge mr) begin
      if (mr)       q <= 1'b0;
      else if (adv) q <= ~q;
   end

   AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (mr)
      adv |=> (q != $past(q))) else $error("toggle stage missed an advance"); // R3
endmodule

// File: rtl/dd_mod_counter.sv
module dd_mod_counter #(
   parameter int unsigned MOD = 5,
   parameter int unsigned W   = (MOD > 1) ? $clog2(MOD) : 1
) (
   input  logic         clk,
   input  logic         mr,
   input  logic         adv,
   output logic [W-1:0] cnt,
   output logic         at_last
);
   localparam logic [W-1:0] LAST    = W'(MOD - 1);
   localparam bit           POW2MOD = ((MOD & (MOD - 1)) == 0);

   generate
      if (MOD < 2) begin : g_bad_mod
         $error("dd_mod_counter: MOD must be at least 2");
      end
   endgenerate

   logic [W-1:0] nxt;

   generate
      if (POW2MOD) begin : g_wrap_free
         assign nxt = cnt + 1'b1;
      end else begin : g_wrap_cmp
         assign nxt = (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   endgenerate

   assign at_last = (cnt == LAST);

   always_ff @(posedge clk or posedge mr) begin
      if (mr)       cnt <= '0;
      else if (adv) cnt <= nxt;
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (mr)
      cnt <= LAST) else $error("modulo stage out of range"); // R4
   AST_CNT_WRAPS: assert property (@(posedge clk) disable iff (mr)
      (adv && at_last) |=> (cnt == '0)) else $error("modulo stage failed to wrap"); // R4
endmodule

// File: rtl/dd_decade_counter.sv
module dd_decade_counter
   import dd_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             mr,
   input  logic             cp0,
   input  logic             cp1,
   input  logic [1:0]       link,
   output logic [OUT_W-1:0] q
);
   link_e              lk;
   logic               fall0, fall1;
   logic               adv_tog, adv_quint;
   logic               tog_q;
   logic [QUINT_W-1:0] quint_q;
   logic               quint_last;

   assign lk = link_e'(link);

   dd_fall_detect #(.STAGES(SYNC_STAGES)) u_fd0 (
      .clk(clk), .mr(mr), .din(cp0), .fall(fall0));
   dd_fall_detect #(.STAGES(SYNC_STAGES)) u_fd1 (
      .clk(clk), .mr(mr), .din(cp1), .fall(fall1));

   always_comb begin
      unique case (lk)
         LINK_BCD: begin
            adv_tog   = fall0;
            adv_quint = fall0 & tog_q;
         end
         LINK_BIQ: begin
            adv_quint = fall1;
            adv_tog   = fall1 & quint_last;
         end
         default: begin
            adv_tog   = fall0;
            adv_quint = fall1;
         end
      endcase
   end

   dd_toggle_stage u_tog (
      .clk(clk), .mr(mr), .adv(adv_tog), .q(tog_q));
   dd_mod_counter #(.MOD(QUINT_MOD), .W(QUINT_W)) u_quint (
      .clk(clk), .mr(mr), .adv(adv_quint), .cnt(quint_q), .at_last(quint_last));

   assign q = {quint_q, tog_q};

   always_ff @(posedge clk) begin
      if (mr) begin
         AST_MR_CLEARS: assert (q == '0) else $error("clear not holding outputs low"); // R1
      end
   end

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (mr)
      (!fall0 && !fall1) |=> (q == $past(q))) else $error("count moved without an edge"); // R2

   AST_SPLIT_Q0_SRC: assert property (@(posedge clk) disable iff (mr)
      ((lk == LINK_SPLIT || lk == LINK_RSVD) && $past(lk) == lk && q[0] != $past(q[0]))
      |-> $past(fall0)) else $error("split mode q0 moved without cp0"); // R5 R8

   AST_BCD_CARRY: assert property (@(posedge clk) disable iff (mr)
      (lk == LINK_BCD && $past(lk) == LINK_BCD && q[3:1] != $past(q[3:1]))
      |-> ($past(q[0]) && !q[0])) else $error("decimal carry not on q0 fall"); // R6

   AST_BCD_NINE_TO_ZERO: assert property (@(posedge clk) disable iff (mr)
      (lk == LINK_BCD && $past(lk) == LINK_BCD && $past(q) == 4'd9 && q != 4'd9)
      |-> (q == 4'd0)) else $error("decimal wrap passed an intermediate value"); // R9

   AST_BIQ_CARRY: assert property (@(posedge clk) disable iff (mr)
      (lk == LINK_BIQ && $past(lk) == LINK_BIQ && q[0] != $past(q[0]))
      |-> ($past(q[3:1]) == 3'd4 && q[3:1] == 3'd0)) else $error("square-wave toggle off the wrap"); // R7
endmodule

// File: tb/dd_decade_counter_tb.sv
`timescale 1ns/1ps
module dd_decade_counter_tb_top;
   logic       clk = 1'b0;
   logic       mr  = 1'b1;
   logic       cp0 = 1'b0;
   logic       cp1 = 1'b0;
   logic [1:0] link = 2'b00;
   logic [3:0] q;

   int n_chk = 0;
   int n_bad = 0;
   bit r2;
   int r5;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dd_decade_counter dut_i (
      .clk(clk), .mr(mr), .cp0(cp0), .cp1(cp1), .link(link), .q(q));

   function automatic logic [3:0] ref_q();
      return {r5[2:0], r2};
   endfunction

   task automatic check(input string tag, input logic [3:0] exp);
      n_chk++;
      if (q !== exp) begin
         n_bad++;
         $display("FAIL %s: q=%0d expected %0d", tag, q, exp);
      end
   endtask

   task automatic check_bit(input string tag, input bit ok, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic model_step(input bit ch);
      case (link)
         2'b01: if (!ch) begin
            if (r2) begin r2 = 1'b0; r5 = (r5 + 1) % 5; end
            else r2 = 1'b1;
         end
         2'b10: if (ch) begin
            if (r5 == 4) begin r5 = 0; r2 = ~r2; end
            else r5 = r5 + 1;
         end
         default: if (ch) r5 = (r5 + 1) % 5; else r2 = ~r2;
      endcase
   endtask

   task automatic pulse(input bit ch);
      @(negedge clk);
      if (ch) cp1 = 1'b1; else cp0 = 1'b1;
      repeat (3) @(negedge clk);
      if (ch) cp1 = 1'b0; else cp0 = 1'b0;
      repeat (4) @(negedge clk);
      model_step(ch);
   endtask

   task automatic do_reset(input logic [1:0] lk);
      @(negedge clk);
      mr = 1'b1; link = lk;
      repeat (2) @(negedge clk);
      mr = 1'b0;
      r2 = 1'b0; r5 = 0;
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      do_reset(2'b00);
      check("R1 reset state", 4'd0);
   endtask

   task automatic t_edge_timing();
      do_reset(2'b00);
      @(negedge clk); cp0 = 1'b1;
      repeat (4) @(negedge clk);
      check("R2 rising edge ignored", 4'd0);
      cp0 = 1'b0;
      repeat (2) @(negedge clk);
      check("R2 not yet counted", 4'd0);
      @(negedge clk);
      check("R2 counted after third clock", 4'd1);
   endtask

   task automatic t_split();
      do_reset(2'b00);
      for (int i = 0; i < 32; i++) begin
         pulse(i % 3 != 0);
         check("R5 split sequence", ref_q());
         check_bit("R4 q3 only at four", q[3] == (r5 == 4), q[3], r5 == 4);
      end
      do_reset(2'b00);
      pulse(1'b0);
      check("R3 toggle first", 4'b0001);
      pulse(1'b0);
      check("R3 toggle back", 4'b0000);
   endtask

   task automatic t_bcd();
      int dec = 0;
      do_reset(2'b01);
      for (int i = 0; i < 30; i++) begin
         pulse(1'b0);
         dec = (dec + 1) % 10;
         check("R6 decimal count", 4'(dec));
         check("R6 reference model", ref_q());
      end
      for (int i = 0; i < 3; i++) begin
         pulse(1'b1);
         check("R6 cp1 ignored", 4'(dec));
      end
      for (int i = 0; i < 9; i++) pulse(1'b0);
      check("R9 reached nine", 4'd9);
      @(negedge clk); cp0 = 1'b1;
      repeat (3) @(negedge clk); cp0 = 1'b0;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         check_bit("R9 no value between 9 and 0", q == 4'd9 || q == 4'd0, q, 0);
      end
      model_step(1'b0);
      check("R9 wrapped to zero", 4'd0);
   endtask

   task automatic t_biq();
      int highs = 0;
      do_reset(2'b10);
      for (int i = 0; i < 30; i++) begin
         pulse(1'b1);
         check("R7 square-wave sequence", ref_q());
         if (q[0]) highs++;
      end
      check_bit("R7 five low five high", highs == 15, highs, 15);
      for (int i = 0; i < 3; i++) begin
         pulse(1'b0);
         check("R7 cp0 ignored", ref_q());
      end
   endtask

   task automatic t_reserved();
      do_reset(2'b11);
      for (int i = 0; i < 12; i++) begin
         pulse(i % 2 == 0);
         check("R8 reserved acts as split", ref_q());
      end
   endtask

   task automatic t_mr_mid();
      do_reset(2'b01);
      for (int i = 0; i < 7; i++) pulse(1'b0);
      check("R1 pre-clear count", 4'd7);
      @(negedge clk); cp0 = 1'b1;
      repeat (3) @(negedge clk); cp0 = 1'b0;
      repeat (2) @(negedge clk);
      mr = 1'b1;
      #0.5;
      check("R1 clear beats pending edge", 4'd0);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         cp0 = ~cp0;
         @(negedge clk);
         check("R1 held while clear high", 4'd0);
      end
      cp0 = 1'b0;
      @(negedge clk); mr = 1'b0;
      r2 = 1'b0; r5 = 0;
      repeat (3) @(negedge clk);
      check("R1 zero after release", 4'd0);
      pulse(1'b0);
      check("R1 resumes from zero", 4'd1);
   endtask

   initial begin
      t_reset_state();
      t_edge_timing();
      t_split();
      t_bcd();
      t_biq();
      t_reserved();
      t_mr_mid();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run hung, got 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule